// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent down-counters behind a flat register port. Software sets a reload value and a control word for each channel. Each channel then counts down to its terminal count and raises a one-cycle interrupt pulse. A channel counts either cycles of the bus clock or rising edges of its own external clock input. The external clock is first brought into the bus clock domain through a two-flop synchroniser. A per-channel gate input can pause counting, and a control bit tells the channel to disregard its gate.

Channel 0 drives the time-slice interrupt and channel 1 drives the garbage-collect interrupt. Channel 2 drives a general-purpose interrupt. A channel in continuous mode reloads itself at terminal count and keeps running. A channel in one-shot mode stops at zero until its control word is written again. Interrupt priority is handled elsewhere.

Top module: `tri_timer`

## Requirements
- R1: After reset every reload, count and control register reads 0 and all three interrupt outputs are low.
- R2: The register address is {channel[3:2], register[1:0]}, where register 0 is reload, 1 is current count and 2 is control. Reload is read/write, and only its low CNT_W bits (16 by default) are stored. A write to the count register has no effect.
- R3: The control word is bit 0 enable, bit 1 continuous (1) or one-shot (0), bit 2 external clock select, and bit 3 gate-ignore. It reads back in bits 3:0 with 0 above. Writing it with enable set copies the reload value into the count on that clock edge.
- R4: When a channel is enabled, uses the bus clock and has its gate open, its count decreases by one on every clock edge.
- R5: When the gate input is low and gate-ignore is clear, the count holds. When gate-ignore is set, the channel counts whatever level the gate has.
- R6: In continuous mode a step taken at count 1 (or 0) reloads the count and raises the channel's interrupt for exactly one cycle. With reload N ≥ 2 and the bus clock, this gives a pulse every N cycles.
- R7: In one-shot mode the terminal step raises a single pulse, leaves the count at 0 and stops the channel. No further pulse occurs until the control word is written again.
- R8: With external clock select set, the count decreases once for each rising edge of that channel's external clock and does not follow bus clock cycles.
- R9: Channel 0 drives irq_slice_o, channel 1 drives irq_gc_o and channel 2 drives irq_gp_o. No channel affects another channel's output.
- R10: Writing the control word with enable clear freezes the count at its current value and raises no pulse.
- R11: Channel index 3 and register index 3 read as 0, and a write to them changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address {channel, register} |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, combinational, 0 when rd_en_i is low |
| ext_clk_i | input | 3 | External clock input, one per channel |
| gate_i | input | 3 | Gate input, one per channel |
| irq_slice_o | output | 1 | Channel 0 terminal-count pulse |
| irq_gc_o | output | 1 | Channel 1 terminal-count pulse |
| irq_gp_o | output | 1 | Channel 2 terminal-count pulse |

## Verification
Assertions check the following on every cycle for each channel:
- An open, running channel steps down by exactly one.
- A closed gate or a stopped channel leaves the count unchanged.
- A continuous pulse is always followed by the previous reload value.
- A one-shot pulse always leaves the channel stopped at zero.

Only the bench scenarios can show the rest:
- The pulse period seen at the ports.
- The mapping of channels to interrupt outputs.
- The count following synchronised external edges rather than bus cycles.
- The register decode for unused addresses.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int unsigned REG_SEL_W = 2;
  localparam logic [REG_SEL_W-1:0] REG_RELOAD = 2'd0;
  localparam logic [REG_SEL_W-1:0] REG_COUNT  = 2'd1;
  localparam logic [REG_SEL_W-1:0] REG_CTRL   = 2'd2;
  localparam int unsigned CTRL_W = 4;

  typedef struct packed {
    logic gate_ign;
    logic ext_sel;
    logic cont;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             step_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             run_q, irq_q;
  logic             term_w;

  // reload 0 behaves as 1: terminal on the step taken at 1 or 0
  assign term_w = (count_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (load_i) begin
      count_q <= reload_i;
      run_q   <= 1'b1;
      irq_q   <= 1'b0;
    end else if (stop_i) begin
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (run_q && step_i) begin
      irq_q <= term_w;
      if (!term_w) begin
        count_q <= count_q - CNT_W'(1);
      end else if (cont_i) begin
        count_q <= reload_i;
      end else begin
        count_q <= '0;
        run_q   <= 1'b0;
      end
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign run_o   = run_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [2:0]        ext_clk_i,
  input  logic [2:0]        gate_i,
  output logic              irq_slice_o,
  output logic              irq_gc_o,
  output logic              irq_gp_o
);
  localparam int unsigned N_CH = 3;

  logic [1:0]           ch_sel;
  logic [REG_SEL_W-1:0] reg_sel;
  assign ch_sel  = addr_i[3:2];
  assign reg_sel = addr_i[1:0];

  logic [N_CH-1:0][CNT_W-1:0] reload_q;
  tmr_ctrl_t [N_CH-1:0]       ctrl_q;
  logic [N_CH-1:0][CNT_W-1:0] count_w;
  logic [N_CH-1:0]            run_w, irq_w, rise_w, tick_w, step_w, cfg_wr_w, cont_w;

  logic unused_w;
  assign unused_w = ^wr_data_i[DATA_W-1:CNT_W];

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign cfg_wr_w[k] = wr_en_i && (ch_sel == 2'(k)) && (reg_sel == REG_CTRL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reload_q[k] <= '0;
        ctrl_q[k]   <= '0;
      end else begin
        if (wr_en_i && (ch_sel == 2'(k)) && (reg_sel == REG_RELOAD))
          reload_q[k] <= wr_data_i[CNT_W-1:0];
        if (cfg_wr_w[k])
          ctrl_q[k] <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      end
    end

    tmr_edge_sync u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_clk_i[k]),
      .rise_o  (rise_w[k])
    );

    assign tick_w[k] = ctrl_q[k].ext_sel ? rise_w[k] : 1'b1;
    assign step_w[k] = tick_w[k] & (gate_i[k] | ctrl_q[k].gate_ign);
    assign cont_w[k] = ctrl_q[k].cont;

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (cfg_wr_w[k] & wr_data_i[0]),
      .stop_i   (cfg_wr_w[k] & ~wr_data_i[0]),
      .step_i   (step_w[k]),
      .cont_i   (cont_w[k]),
      .reload_i (reload_q[k]),
      .count_o  (count_w[k]),
      .run_o    (run_w[k]),
      .irq_o    (irq_w[k])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (rd_en_i && (ch_sel == 2'(k))) begin
        case (reg_sel)
          REG_RELOAD: rd_data_o[CNT_W-1:0]  = reload_q[k];
          REG_COUNT:  rd_data_o[CNT_W-1:0]  = count_w[k];
          REG_CTRL:   rd_data_o[CTRL_W-1:0] = ctrl_q[k];
          default:    rd_data_o = '0;
        endcase
      end
    end
  end

  assign irq_slice_o = irq_w[0];
  assign irq_gc_o    = irq_w[1];
  assign irq_gp_o    = irq_w[2];
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CH-1:0][CNT_W-1:0] count_w,
  input logic [N_CH-1:0][CNT_W-1:0] reload_q,
  input logic [N_CH-1:0]            run_w,
  input logic [N_CH-1:0]            irq_w,
  input logic [N_CH-1:0]            step_w,
  input logic [N_CH-1:0]            cfg_wr_w,
  input logic [N_CH-1:0]            cont_w
);
  for (genvar k = 0; k < N_CH; k++) begin : g_a
    a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[k] && step_w[k] && !cfg_wr_w[k] && count_w[k] > CNT_W'(1))
      |=> count_w[k] == $past(count_w[k]) - CNT_W'(1));

    a_r5_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_w[k] && !cfg_wr_w[k]) |=> $stable(count_w[k]));

    a_r6_cont_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_w[k] && cont_w[k]) |-> count_w[k] == $past(reload_q[k]));

    a_r7_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_w[k] && !cont_w[k]) |-> (count_w[k] == '0 && !run_w[k]));

    a_r10_idle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[k] && !cfg_wr_w[k]) |=> ($stable(count_w[k]) && !irq_w[k]));
  end
endmodule

bind tri_timer tri_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .count_w  (count_w),
  .reload_q (reload_q),
  .run_w    (run_w),
  .irq_w    (irq_w),
  .step_w   (step_w),
  .cfg_wr_w (cfg_wr_w),
  .cont_w   (cont_w)
);

// File: tb/tri_timer_tb_top.sv
module tri_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  ext_clk = '0;
  logic [2:0]  gate = '0;
  logic        irq_slice, irq_gc, irq_gp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tri_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wr_data_i   (wdata),
    .rd_en_i     (rd_en),
    .rd_data_o   (rdata),
    .ext_clk_i   (ext_clk),
    .gate_i      (gate),
    .irq_slice_o (irq_slice),
    .irq_gc_o    (irq_gc),
    .irq_gp_o    (irq_gp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < 3; r++) begin
        rd(4'(c * 4 + r), d);
        check("R1 reg reset", d, 0);
      end
    end
    check("R1 irq reset", {irq_slice, irq_gc, irq_gp}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'h0, 32'hABCD_1234);
    rd(4'h0, d); check("R2 reload readback", d, 32'h1234);
    wr(4'h1, 32'h0000_5555);
    rd(4'h1, d); check("R2 count read-only", d, 0);
    wr(4'hC, 32'h0000_7777);
    rd(4'hC, d); check("R11 channel 3 reads 0", d, 0);
    rd(4'h3, d); check("R11 register 3 reads 0", d, 0);
    rd(4'h0, d); check("R11 ch0 reload untouched", d, 32'h1234);
    rd(4'h4, d); check("R11 ch1 reload untouched", d, 0);
    rd(4'h8, d); check("R11 ch2 reload untouched", d, 0);
  endtask

  task automatic t_bus_count;
    logic [31:0] d;
    wr(4'h0, 10);
    wr(4'h2, 32'hFFF0_0009);
    rd(4'h2, d); check("R3 ctrl readback", d, 32'h9);
    rd(4'h1, d); check("R3 load on enable", d, 10);
    wait_n(3);
    rd(4'h1, d); check("R4 bus-clock decrement", d, 7);
    wr(4'h2, 0);
    rd(4'h1, d); check("R10 stop freezes count", d, 6);
    wait_n(8);
    rd(4'h1, d); check("R10 count held", d, 6);
    check("R10 no pulse", irq_slice, 0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(4'h4, 20);
    wr(4'h6, 32'h1);
    wait_n(5);
    rd(4'h5, d); check("R5 gate low holds", d, 20);
    gate[1] = 1'b1;
    wait_n(3);
    rd(4'h5, d); check("R5 gate high counts", d, 17);
    gate[1] = 1'b0;
    wait_n(4);
    rd(4'h5, d); check("R5 gate low holds again", d, 17);
    wr(4'h6, 32'h9);
    wait_n(2);
    rd(4'h5, d); check("R5 gate-ignore counts", d, 18);
    wr(4'h6, 0);
  endtask

  task automatic t_continuous;
    wr(4'h0, 5);
    wr(4'h2, 32'hB);
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      check("R6 continuous pulse period", irq_slice, 32'((i % 5) == 0));
      check("R9 slice isolation", {irq_gc, irq_gp}, 0);
    end
    wr(4'h2, 0);
    wr(4'h4, 3);
    wr(4'h6, 32'hB);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check("R9 gc output", irq_gc, 32'((i % 3) == 0));
      check("R9 gc isolation", {irq_slice, irq_gp}, 0);
    end
    wr(4'h6, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    for (int pass = 0; pass < 2; pass++) begin
      wr(4'h8, 4);
      wr(4'hA, 32'h9);
      for (int i = 1; i <= 12; i++) begin
        @(negedge clk);
        check("R7 one-shot single pulse", irq_gp, 32'(i == 4));
        check("R9 gp isolation", {irq_slice, irq_gc}, 0);
      end
      rd(4'h9, d); check("R7 one-shot rests at 0", d, 0);
    end
  endtask

  task automatic t_ext;
    logic [31:0] d;
    wr(4'h8, 100);
    wr(4'hA, 32'hF);
    wait_n(5);
    rd(4'h9, d); check("R8 no count without edges", d, 100);
    for (int e = 0; e < 6; e++) begin
      @(negedge clk); ext_clk[2] = 1'b1;
      wait_n(3);
      ext_clk[2] = 1'b0;
      wait_n(2);
    end
    wait_n(6);
    rd(4'h9, d); check("R8 one step per edge", d, 94);
    wr(4'hA, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_bus_count;
    t_gate;
    t_continuous;
    t_oneshot;
    t_ext;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule